// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block merges up to 32 interrupt inputs into a single request line for a processor. Every input has a mode word, which sets its priority level and whether it is sensed by level or by rising edge, and a vector word, which holds the address of its handler. Software enables and masks inputs by writing bitmasks. Pending edge inputs are cleared the same way.

When the processor takes the interrupt, it reads the vector register. That read is also the acknowledge. It returns the handler address of the winning input and pushes the winning priority onto an internal stack of eight levels. While a priority sits on top of the stack, only inputs with a strictly higher priority can raise the request line again, which is how nested preemption works. A write to the end-of-service register pops one level. Eight such writes always drain the stack, which lets software recover after the core alone was reset.

Register access uses a simple synchronous port. Read data appears in the cycle after the request.

Top module: `vpic`

## Requirements
- R1: After reset the request line is low, the enable mask reads 0, every mode and vector word is 0, the spurious vector is 0 and the priority stack is empty.
- R2: A write to ENSET (0x108) enables the inputs whose bits are 1. A write to ENCLR (0x10C) disables them. Bits that are 0 leave their inputs unchanged. ENMASK (0x118) reads back the enable mask, and a disabled input never raises the request line.
- R3: The mode word of input i is at byte address 4*i. Bits [2:0] hold its priority, from 0 (lowest) to 7 (highest), and bit 4 selects edge (1) or level (0) sensing. Among enabled pending inputs the highest priority wins, and on equal priority the lowest input number wins.
- R4: A read of VEC (0x100) returns the vector word of the winner and pushes its priority. The request line is high only when some enabled pending input has a priority strictly above the top of the stack, or when the stack is empty and some enabled input is pending.
- R5: Any write to EOI (0x114) pops one stack level, after which inputs at or below the popped priority can request again. A pop of an empty stack has no effect.
- R6: A VEC read that finds no input allowed to request returns the spurious vector (read/write at 0x104) and leaves the stack unchanged.
- R7: A level input is pending while its input pin is high. An edge input latches a rising edge and stays pending until a write to EDGECLR (0x110) with its bit set, or until a VEC read acknowledges it.
- R8: After eight EOI writes the stack is empty, no matter how many levels it held.
- R9: The vector word of input i is read/write at byte address 0x80+4*i, and the mode words read back as written (bits [2:0] and bit 4, other bits 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Interrupt inputs, one per source |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The main function is driven with single level inputs, with two inputs of equal priority asserted together (this separates the lowest-number tie break from the alternatives), and with a higher priority input raised while a lower one is in service (this separates strict preemption from simple highest-wins selection). Edge inputs are pulsed for one cycle and then cleared either by the bitmask or by acknowledge, which shows latching apart from level following. A vector read with only a blocked input pending, followed by a single end-of-service write, shows whether the spurious path pushed the stack. A ladder of eight nested acknowledges followed by eight pops shows the stack depth and that it drains to empty.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int PRIO_W = 3;
    localparam int SLOT_W = 5;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam logic [9:0] OFS_VEC    = 10'h100;
    localparam logic [9:0] OFS_SPUR   = 10'h104;
    localparam logic [9:0] OFS_ENSET  = 10'h108;
    localparam logic [9:0] OFS_ENCLR  = 10'h10C;
    localparam logic [9:0] OFS_EDGECL = 10'h110;
    localparam logic [9:0] OFS_EOI    = 10'h114;
    localparam logic [9:0] OFS_ENMASK = 10'h118;

    localparam int MODE_EDGE_BIT = 4;
endpackage

// File: rtl/vpic_src_bank.sv
module vpic_src_bank
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               irq_in,
    input  logic                             cfg_we,
    input  logic                             cfg_is_vec,
    input  logic [SLOT_W-1:0]                cfg_idx,
    input  logic [DATA_W-1:0]                cfg_wdata,
    input  logic [NUM_SRC-1:0]               en_set,
    input  logic [NUM_SRC-1:0]               en_clr,
    input  logic [NUM_SRC-1:0]               edge_clr,
    input  logic                             ack_valid,
    input  logic [SLOT_W-1:0]                ack_idx,
    output logic [NUM_SRC-1:0]               en_o,
    output logic [NUM_SRC-1:0]               edge_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o,
    output logic [NUM_SRC-1:0][DATA_W-1:0]   vec_o,
    output logic [NUM_SRC-1:0]               active_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0]             en;
        logic [NUM_SRC-1:0]             edge_sel;
        logic [NUM_SRC-1:0]             pend;
        logic [NUM_SRC-1:0]             prev;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0][DATA_W-1:0] vec;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;
        st_d.en   = (st_q.en | en_set) & ~en_clr;
        for (int i = 0; i < NUM_SRC; i++) begin
            logic hit, rise, acked;
            hit   = cfg_we && (int'(cfg_idx) == i);
            rise  = irq_in[i] && !st_q.prev[i];
            acked = ack_valid && (int'(ack_idx) == i);
            if (hit && !cfg_is_vec) begin
                st_d.prio[i]     = cfg_wdata[PRIO_W-1:0];
                st_d.edge_sel[i] = cfg_wdata[MODE_EDGE_BIT];
            end
            if (hit && cfg_is_vec) begin
                st_d.vec[i] = cfg_wdata;
            end
            if (st_q.edge_sel[i]) begin
                st_d.pend[i] = (st_q.pend[i] && !edge_clr[i] && !acked) || rise;
            end else begin
                st_d.pend[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o     = st_q.en;
    assign edge_o   = st_q.edge_sel;
    assign prio_o   = st_q.prio;
    assign vec_o    = st_q.vec;
    assign active_o = st_q.en & ((st_q.edge_sel & st_q.pend) | (~st_q.edge_sel & irq_in));
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]             active,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic                           found,
    output logic [SLOT_W-1:0]              win_idx,
    output logic [PRIO_W-1:0]              win_prio
);
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && (!found || (prio[i] > win_prio))) begin
                found    = 1'b1;
                win_idx  = SLOT_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/vpic_prio_stack.sv
module vpic_prio_stack
    import vpic_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [PRIO_W-1:0]            push_prio,
    input  logic                         pop,
    output logic [$clog2(DEPTH+1)-1:0]   depth_o,
    output logic [PRIO_W-1:0]            top_o,
    output logic                         empty_o
);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] ent;
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push && (int'(st_q.cnt) < DEPTH)) begin
            st_d.ent[st_q.cnt] = push_prio;
            st_d.cnt           = st_q.cnt + CNT_W'(1);
        end else if (pop && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign depth_o = st_q.cnt;
    assign empty_o = (st_q.cnt == '0);
    assign top_o   = empty_o ? '0 : st_q.ent[st_q.cnt - CNT_W'(1)];
endmodule

// File: rtl/vpic.sv
module vpic
    import vpic_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 10,
    parameter int STK_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    localparam int CNT_W = $clog2(STK_DEPTH+1);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] spur;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_SRC-1:0]             en_mask, edge_mask, active;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_arr;
    logic [NUM_SRC-1:0][DATA_W-1:0] vec_arr;
    logic                           arb_found;
    logic [SLOT_W-1:0]              arb_idx;
    logic [PRIO_W-1:0]              arb_prio;
    logic [CNT_W-1:0]               stk_depth;
    logic [PRIO_W-1:0]              stk_top;
    logic                           stk_empty;

    logic [9:0]         a10;
    logic               rd, wr, cfg_space;
    logic               vec_rd, qualify, push, pop;
    logic [NUM_SRC-1:0] en_set, en_clr, edge_clr;
    logic [SLOT_W-1:0]  slot;

    assign a10       = 10'(bus_addr);
    assign rd        = bus_sel && !bus_wr;
    assign wr        = bus_sel && bus_wr;
    assign cfg_space = (a10[9:8] == 2'b00);
    assign slot      = a10[6:2];
    assign vec_rd    = rd && (a10 == OFS_VEC);
    assign qualify   = arb_found && (stk_empty || (arb_prio > stk_top));
    assign push      = vec_rd && qualify;
    assign pop       = wr && (a10 == OFS_EOI);
    assign en_set    = (wr && a10 == OFS_ENSET)  ? bus_wdata[NUM_SRC-1:0] : '0;
    assign en_clr    = (wr && a10 == OFS_ENCLR)  ? bus_wdata[NUM_SRC-1:0] : '0;
    assign edge_clr  = (wr && a10 == OFS_EDGECL) ? bus_wdata[NUM_SRC-1:0] : '0;

    vpic_src_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .cfg_we     (wr && cfg_space),
        .cfg_is_vec (a10[7]),
        .cfg_idx    (slot),
        .cfg_wdata  (bus_wdata),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .edge_clr   (edge_clr),
        .ack_valid  (push),
        .ack_idx    (arb_idx),
        .en_o       (en_mask),
        .edge_o     (edge_mask),
        .prio_o     (prio_arr),
        .vec_o      (vec_arr),
        .active_o   (active)
    );

    vpic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .active   (active),
        .prio     (prio_arr),
        .found    (arb_found),
        .win_idx  (arb_idx),
        .win_prio (arb_prio)
    );

    vpic_prio_stack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_prio (arb_prio),
        .pop       (pop),
        .depth_o   (stk_depth),
        .top_o     (stk_top),
        .empty_o   (stk_empty)
    );

    always_comb begin
        st_d = st_q;
        if (wr && (a10 == OFS_SPUR)) begin
            st_d.spur = bus_wdata;
        end
        if (rd) begin
            st_d.rdata = '0;
            if (cfg_space) begin
                if (int'(slot) < NUM_SRC) begin
                    if (a10[7]) begin
                        st_d.rdata = vec_arr[slot];
                    end else begin
                        st_d.rdata[PRIO_W-1:0]    = prio_arr[slot];
                        st_d.rdata[MODE_EDGE_BIT] = edge_mask[slot];
                    end
                end
            end else begin
                case (a10)
                    OFS_VEC:    st_d.rdata = qualify ? vec_arr[arb_idx] : st_q.spur;
                    OFS_SPUR:   st_d.rdata = st_q.spur;
                    OFS_ENMASK: st_d.rdata[NUM_SRC-1:0] = en_mask;
                    default:    st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq_o     = qualify;
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int CNT_W   = 4,
    parameter int DEPTH   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] en_mask,
    input logic               arb_found,
    input logic               push,
    input logic               pop,
    input logic [CNT_W-1:0]   depth,
    input logic [PRIO_W-1:0]  top
);
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth) <= DEPTH); // R8
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |-> !irq_o); // R2
    AST_IRQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> arb_found); // R3
    AST_PUSH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (push && depth != '0) |=> (top > $past(top))); // R4
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && depth != '0) |=> (depth == $past(depth) - CNT_W'(1))); // R5
    AST_NO_SPURIOUS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> irq_o); // R6
endmodule

bind vpic vpic_chk #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .DEPTH(STK_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .en_mask   (en_mask),
    .arb_found (arb_found),
    .push      (push),
    .pop       (pop),
    .depth     (stk_depth),
    .top       (stk_top)
);

// File: tb/vpic_tb.sv
module vpic_tb;
    localparam int N = 32;
    localparam logic [31:0] SPUR = 32'hDEAD_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    bit rd_live = 0;
    string       tag_q[$];
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    vpic u_dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o));

    function automatic logic [31:0] vec_of(int i);
        return 32'h1000_0000 + 32'(i * 16);
    endfunction

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        tag_q.push_back(t); exp_q.push_back(e); rd_live = 1;
        @(negedge clk);
        bus_sel = 1'b0; rd_live = 0;
    endtask

    task automatic set_in(input int i, input logic v);
        @(negedge clk);
        irq_in[i] = v;
    endtask

    task automatic check_irq(input logic e, input string t);
        @(negedge clk);
        #2;
        n_cmp++;
        if (irq_o !== e) begin
            n_bad++;
            $display("FAIL %s irq: actual=%b expected=%b", t, irq_o, e);
        end
    endtask

    // monitor: pop the expected read value once the registered data appears
    always @(posedge clk) begin
        if (rd_live) begin
            string t;
            logic [31:0] e;
            #2;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s read: actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_irq(1'b0, "R1");
        bus_read(10'h118, 32'h0, "R1 enmask");
        bus_read(10'h100, 32'h0, "R1 spurious reset");
        bus_read(10'h000 + 10'd40, 32'h0, "R1 mode");

        bus_write(10'h104, SPUR);
        for (int i = 0; i < N; i++) bus_write(10'h080 + 10'(4 * i), vec_of(i));
        bus_write(10'h000 + 10'd12, 32'h2);      // src3 prio2 level
        bus_write(10'h000 + 10'd20, 32'h2);      // src5 prio2 level
        bus_write(10'h000 + 10'd40, 32'h5);      // src10 prio5 level
        bus_write(10'h000 + 10'd80, 32'h17);     // src20 prio7 edge
        for (int i = 24; i < 32; i++) bus_write(10'(4 * i), 32'(i - 24));
        // R9 readback
        bus_read(10'h000 + 10'd80, 32'h17, "R9 mode");
        bus_read(10'h080 + 10'd80, vec_of(20), "R9 vector");

        // R2 enable gating
        set_in(3, 1'b1);
        check_irq(1'b0, "R2 disabled");
        bus_write(10'h108, 32'h0000_0428);
        bus_read(10'h118, 32'h0000_0428, "R2 enmask");
        check_irq(1'b1, "R2 enabled");

        // R3 tie, R4 preemption, R5 pops
        set_in(5, 1'b1);
        bus_read(10'h100, vec_of(3), "R3 tie lowest");
        check_irq(1'b0, "R4 equal blocked");
        set_in(10, 1'b1);
        check_irq(1'b1, "R4 higher preempts");
        bus_read(10'h100, vec_of(10), "R3 highest");
        check_irq(1'b0, "R4 in service");
        bus_write(10'h114, 32'h0);
        check_irq(1'b1, "R5 pop reopens");
        set_in(10, 1'b0);
        check_irq(1'b0, "R4 only equal left");
        bus_write(10'h114, 32'h0);
        check_irq(1'b1, "R5 empty");
        set_in(3, 1'b0); set_in(5, 1'b0);
        check_irq(1'b0, "R7 level follows");

        // R7 edge latch / clear / acknowledge
        bus_write(10'h108, 32'h0010_0000);
        set_in(20, 1'b1); set_in(20, 1'b0);
        check_irq(1'b1, "R7 latched");
        bus_write(10'h110, 32'h0010_0000);
        check_irq(1'b0, "R7 cleared");
        set_in(20, 1'b1); set_in(20, 1'b0);
        bus_read(10'h100, vec_of(20), "R7 edge vector");
        bus_write(10'h114, 32'h0);
        check_irq(1'b0, "R7 ack clears");

        // R6 spurious with no push
        set_in(10, 1'b1);
        bus_read(10'h100, vec_of(10), "R6 setup");
        set_in(3, 1'b1);
        check_irq(1'b0, "R6 blocked");
        bus_read(10'h100, SPUR, "R6 spurious");
        bus_write(10'h114, 32'h0);
        check_irq(1'b1, "R6 no push");
        set_in(10, 1'b0); set_in(3, 1'b0);

        // R8 eight nested levels then eight pops
        bus_write(10'h108, 32'hFF00_0000);
        for (int i = 24; i < 32; i++) begin
            set_in(i, 1'b1);
            bus_read(10'h100, vec_of(i), "R8 ladder");
        end
        check_irq(1'b0, "R8 full");
        for (int i = 25; i < 32; i++) set_in(i, 1'b0);
        for (int k = 0; k < 7; k++) bus_write(10'h114, 32'h0);
        check_irq(1'b0, "R8 one level left");
        bus_write(10'h114, 32'h0);
        check_irq(1'b1, "R8 drained");
        bus_write(10'h114, 32'h0);
        check_irq(1'b1, "R5 pop empty harmless");

        // R2 disable all
        bus_write(10'h10C, 32'hFFFF_FFFF);
        check_irq(1'b0, "R2 all masked");
        bus_read(10'h118, 32'h0, "R2 enmask cleared");

        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule